// File: doc/BRIEF.md
# Framed byte-stream packet codec

This block converts between a flat byte stream and a stream of packet bytes that carry start and end flags, in both directions. The receive half scans incoming line bytes for four reserved codes. These codes mark the start of a packet, mark the last byte, select a channel and escape a byte. The receive half removes the codes and undoes the escaping. It presents each data byte with a start flag on the first byte of a packet and an end flag on the last one. The transmit half takes flagged packet bytes and produces the matching line stream. It opens every packet with a start code followed by a channel code and the channel number zero. It places the end code ahead of the final data byte, not after it. It escapes any data byte that collides with a reserved code.

All four stream edges use valid/ready handshakes. The receive half checks that the channel number is zero and detects misplaced reserved codes. On any such error it raises a sticky error flag, stops emitting the current packet and hunts for the next start code.

Receive states: `D_HUNT` (discard until a start code), `D_BODY` (inside a packet), `D_CHNUM` (next byte is the channel number), `D_ESC` (next byte is escaped), `D_LAST` (next data byte ends the packet), `D_LAST_ESC` (the final byte is escaped).

Receive transitions:
- start code → `D_BODY` from any state except `D_CHNUM`.
- `D_BODY` → `D_CHNUM` on the channel code, → `D_ESC` on the escape code, → `D_LAST` on the end code.
- `D_CHNUM` → `D_BODY` on zero. Any other value is an error and goes to `D_HUNT`.
- `D_ESC` → `D_BODY` on a data byte.
- `D_LAST` → `D_LAST_ESC` on the escape code, → `D_HUNT` on a data byte.
- `D_LAST_ESC` → `D_HUNT` on a data byte.
- Every protocol error → `D_HUNT`.

Transmit states: `E_IDLE`, `E_SOP`, `E_CHAN`, `E_CHNUM`, `E_EOPM`, `E_ESC`, `E_DATA`.

Transmit transitions:
- `E_IDLE` or `E_DATA` accepts a byte. It goes to `E_SOP` for a first byte, else to `E_EOPM` for a last byte, else to `E_ESC` for a colliding byte, else to `E_DATA`.
- `E_SOP` → `E_CHAN` → `E_CHNUM`. `E_CHNUM` then goes to `E_EOPM`, `E_ESC` or `E_DATA` by the same rule.
- `E_EOPM` → `E_ESC` or `E_DATA`.
- `E_ESC` → `E_DATA`.
- `E_DATA` → `E_IDLE` when no new byte is taken.

Top module: `pfc_codec`

## Requirements
- R1: The reserved codes are 0x7A (start), 0x7B (end marker), 0x7C (channel) and 0x7D (escape). The transmitter sends a data byte equal to any of them as 0x7D followed by the byte XOR 0x20. A byte that follows 0x7D on the line is never a reserved code.
- R2: For a packet byte flagged as first, the transmitter emits 0x7A, 0x7C, 0x00 before that byte. The line byte after 0x7C is always 0x00.
- R3: For a packet byte flagged as last, the transmitter emits 0x7B immediately before that byte's encoding, ahead of its escape code if it has one.
- R4: The receiver emits nothing for bytes seen before the first 0x7A or after a packet has ended.
- R5: The receiver emits each data byte, XORing it with 0x20 when it follows 0x7D. It flags the first data byte after 0x7A as start and the data byte after 0x7B as end. On the output, bit sop is dp_sop and bit eop is dp_eop.
- R6: A channel-number byte other than 0x00 sets the error flag. The receiver then emits nothing until the next 0x7A.
- R7: Each of the following sets the error flag and drops the rest of the packet: 0x7D after 0x7D, 0x7B or 0x7C after 0x7D, 0x7B or 0x7C after 0x7B.
- R8: A 0x7A inside a packet restarts parsing, and the next data byte is flagged as start.
- R9: After reset the error flag is 0, neither output is valid and the transmitter is ready. The error flag then stays 1 until reset.
- R10: An output held valid without ready keeps its byte and flags unchanged, and no byte is lost or repeated under back-pressure.
- R11: The transmitter's line stream fed into the receiver reproduces the original packet bytes and flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Line byte into receiver valid |
| rx_ready | output | 1 | Receiver accepts a line byte |
| rx_byte | input | 8 | Line byte into receiver |
| dp_valid | output | 1 | Decoded packet byte valid |
| dp_ready | input | 1 | Sink accepts decoded byte |
| dp_data | output | 8 | Decoded packet byte |
| dp_sop | output | 1 | Decoded byte is first of packet |
| dp_eop | output | 1 | Decoded byte is last of packet |
| proto_err | output | 1 | Sticky protocol error flag |
| ep_valid | input | 1 | Packet byte into transmitter valid |
| ep_ready | output | 1 | Transmitter accepts a packet byte |
| ep_data | input | 8 | Packet byte into transmitter |
| ep_sop | input | 1 | Packet byte is first of packet |
| ep_eop | input | 1 | Packet byte is last of packet |
| tx_valid | output | 1 | Line byte from transmitter valid |
| tx_ready | input | 1 | Line sink accepts a byte |
| tx_byte | output | 8 | Line byte from transmitter |

## Verification
The hold checks on both outputs assume that every upstream source keeps its valid, byte and flags steady until the handshake completes. They also assume that the packet source flags exactly one first and one last byte per packet. The bench drivers change inputs only after a completed handshake and build every packet with exactly one start flag and one end flag. The sinks' ready lines follow a free-running pseudo-random pattern, so stalls land in every encoder and decoder state.

// File: rtl/pfc_pkg.sv
package pfc_pkg;
    localparam int BYTE_W = 8;

    localparam logic [BYTE_W-1:0] CH_SOP   = 8'h7A;
    localparam logic [BYTE_W-1:0] CH_EOP   = 8'h7B;
    localparam logic [BYTE_W-1:0] CH_CHAN  = 8'h7C;
    localparam logic [BYTE_W-1:0] CH_ESC   = 8'h7D;
    localparam logic [BYTE_W-1:0] ESC_MASK = 8'h20;
    localparam logic [BYTE_W-1:0] CHAN_ID  = 8'h00;

    typedef enum logic [2:0] {
        D_HUNT, D_BODY, D_CHNUM, D_ESC, D_LAST, D_LAST_ESC
    } dec_state_e;

    typedef enum logic [2:0] {
        E_IDLE, E_SOP, E_CHAN, E_CHNUM, E_EOPM, E_ESC, E_DATA
    } enc_state_e;

    function automatic logic is_special(input logic [BYTE_W-1:0] b);
        return (b == CH_SOP) || (b == CH_EOP) || (b == CH_CHAN) || (b == CH_ESC);
    endfunction
endpackage

// File: rtl/pfc_decoder.sv
module pfc_decoder
    import pfc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [BYTE_W-1:0] in_byte,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [BYTE_W-1:0] out_data,
    output logic              out_sop,
    output logic              out_eop,
    output logic              err
);
    dec_state_e        st, nxt;
    logic              first, nfirst;
    logic              emit, elast, set_err, acc, tail, escd;
    logic [BYTE_W-1:0] ebyte;

    assign in_ready = !out_valid || out_ready;
    assign acc      = in_valid && in_ready;
    assign tail     = (st == D_LAST) || (st == D_LAST_ESC);
    assign escd     = (st == D_ESC)  || (st == D_LAST_ESC);

    always_comb begin
        nxt     = st;
        nfirst  = first;
        emit    = 1'b0;
        elast   = 1'b0;
        set_err = 1'b0;
        ebyte   = in_byte;
        if (acc) begin
            unique case (st)
                D_HUNT: begin
                    if (in_byte == CH_SOP) begin
                        nxt    = D_BODY;
                        nfirst = 1'b1;
                    end
                end
                D_CHNUM: begin
                    if (in_byte == CHAN_ID) begin
                        nxt = D_BODY;
                    end else begin
                        set_err = 1'b1;
                        nxt     = D_HUNT;
                    end
                end
                D_BODY, D_ESC, D_LAST, D_LAST_ESC: begin
                    if (in_byte == CH_SOP) begin
                        nxt    = D_BODY;
                        nfirst = 1'b1;
                    end else if (in_byte == CH_ESC) begin
                        if (escd) begin
                            set_err = 1'b1;
                            nxt     = D_HUNT;
                        end else begin
                            nxt = tail ? D_LAST_ESC : D_ESC;
                        end
                    end else if (in_byte == CH_EOP || in_byte == CH_CHAN) begin
                        if (escd || tail) begin
                            set_err = 1'b1;
                            nxt     = D_HUNT;
                        end else begin
                            nxt = (in_byte == CH_EOP) ? D_LAST : D_CHNUM;
                        end
                    end else begin
                        emit   = 1'b1;
                        ebyte  = escd ? (in_byte ^ ESC_MASK) : in_byte;
                        elast  = tail;
                        nfirst = 1'b0;
                        nxt    = tail ? D_HUNT : D_BODY;
                    end
                end
                default: nxt = D_HUNT;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= D_HUNT;
            first <= 1'b0;
        end else begin
            st    <= nxt;
            first <= nfirst;
        end
    end

    // output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_sop   <= 1'b0;
            out_eop   <= 1'b0;
            err       <= 1'b0;
        end else begin
            if (emit) begin
                out_valid <= 1'b1;
                out_data  <= ebyte;
                out_sop   <= first;
                out_eop   <= elast;
            end else if (out_ready) begin
                out_valid <= 1'b0;
            end
            if (set_err) err <= 1'b1;
        end
    end
endmodule

// File: rtl/pfc_encoder.sv
module pfc_encoder
    import pfc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pk_valid,
    output logic              pk_ready,
    input  logic [BYTE_W-1:0] pk_data,
    input  logic              pk_sop,
    input  logic              pk_eop,
    output logic              ln_valid,
    input  logic              ln_ready,
    output logic [BYTE_W-1:0] ln_byte
);
    enc_state_e        st, nxt;
    logic [BYTE_W-1:0] hold_b;
    logic              hold_eop, hold_spec, take;

    function automatic enc_state_e body_entry(input logic eop, input logic spec);
        if (eop)  return E_EOPM;
        if (spec) return E_ESC;
        return E_DATA;
    endfunction

    function automatic enc_state_e entry(input logic sop, input logic eop,
                                         input logic [BYTE_W-1:0] b);
        if (sop) return E_SOP;
        return body_entry(eop, is_special(b));
    endfunction

    assign pk_ready = (st == E_IDLE) || (st == E_DATA && ln_ready);
    assign take     = pk_valid && pk_ready;

    always_comb begin
        nxt = st;
        unique case (st)
            E_IDLE:  if (take) nxt = entry(pk_sop, pk_eop, pk_data);
            E_SOP:   if (ln_ready) nxt = E_CHAN;
            E_CHAN:  if (ln_ready) nxt = E_CHNUM;
            E_CHNUM: if (ln_ready) nxt = body_entry(hold_eop, hold_spec);
            E_EOPM:  if (ln_ready) nxt = hold_spec ? E_ESC : E_DATA;
            E_ESC:   if (ln_ready) nxt = E_DATA;
            E_DATA:  if (ln_ready) nxt = take ? entry(pk_sop, pk_eop, pk_data) : E_IDLE;
            default: nxt = E_IDLE;
        endcase
    end

    // state register and captured byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= E_IDLE;
            hold_b    <= '0;
            hold_eop  <= 1'b0;
            hold_spec <= 1'b0;
        end else begin
            st <= nxt;
            if (take) begin
                hold_b    <= pk_data;
                hold_eop  <= pk_eop;
                hold_spec <= is_special(pk_data);
            end
        end
    end

    // line outputs
    always_comb begin
        ln_valid = (st != E_IDLE);
        unique case (st)
            E_SOP:   ln_byte = CH_SOP;
            E_CHAN:  ln_byte = CH_CHAN;
            E_CHNUM: ln_byte = CHAN_ID;
            E_EOPM:  ln_byte = CH_EOP;
            E_ESC:   ln_byte = CH_ESC;
            E_DATA:  ln_byte = hold_spec ? (hold_b ^ ESC_MASK) : hold_b;
            default: ln_byte = '0;
        endcase
    end
endmodule

// File: rtl/pfc_codec.sv
module pfc_codec
    import pfc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    output logic              rx_ready,
    input  logic [BYTE_W-1:0] rx_byte,
    output logic              dp_valid,
    input  logic              dp_ready,
    output logic [BYTE_W-1:0] dp_data,
    output logic              dp_sop,
    output logic              dp_eop,
    output logic              proto_err,
    input  logic              ep_valid,
    output logic              ep_ready,
    input  logic [BYTE_W-1:0] ep_data,
    input  logic              ep_sop,
    input  logic              ep_eop,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [BYTE_W-1:0] tx_byte
);
    pfc_decoder u_dec (
        .clk(clk), .rst_n(rst_n),
        .in_valid(rx_valid), .in_ready(rx_ready), .in_byte(rx_byte),
        .out_valid(dp_valid), .out_ready(dp_ready), .out_data(dp_data),
        .out_sop(dp_sop), .out_eop(dp_eop), .err(proto_err)
    );

    pfc_encoder u_enc (
        .clk(clk), .rst_n(rst_n),
        .pk_valid(ep_valid), .pk_ready(ep_ready), .pk_data(ep_data),
        .pk_sop(ep_sop), .pk_eop(ep_eop),
        .ln_valid(tx_valid), .ln_ready(tx_ready), .ln_byte(tx_byte)
    );
endmodule

// File: rtl/pfc_codec_chk.sv
module pfc_codec_chk
    import pfc_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              dp_valid,
    input logic              dp_ready,
    input logic [BYTE_W-1:0] dp_data,
    input logic              dp_sop,
    input logic              dp_eop,
    input logic              proto_err,
    input logic              tx_valid,
    input logic              tx_ready,
    input logic [BYTE_W-1:0] tx_byte
);
    logic after_esc, after_chan;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            after_esc  <= 1'b0;
            after_chan <= 1'b0;
        end else if (tx_valid && tx_ready) begin
            after_esc  <= (tx_byte == CH_ESC);
            after_chan <= (tx_byte == CH_CHAN);
        end
    end

    // R1
    r1_esc_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && after_esc) |-> !is_special(tx_byte));

    // R2
    r2_chan_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && after_chan) |-> (tx_byte == CHAN_ID));

    // R9
    r9_err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |=> proto_err);

    // R10
    r10_dp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dp_valid && !dp_ready) |=>
            (dp_valid && $stable(dp_data) && $stable(dp_sop) && $stable(dp_eop)));

    // R10
    r10_tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_byte)));
endmodule

bind pfc_codec pfc_codec_chk u_chk (.*);

// File: tb/tb_pfc_codec.sv
module tb_pfc_codec;
    import pfc_pkg::*;

    typedef logic [7:0] bq_t[$];
    typedef logic [9:0] dq_t[$];

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst_n = 1'b0;
    logic       loop = 1'b0, bp_en = 1'b0;
    logic       rv_drv = 1'b0, ep_valid = 1'b0, ep_sop = 1'b0, ep_eop = 1'b0;
    logic [7:0] rb_drv = '0, ep_data = '0;
    logic [15:0] lfsr = 16'hACE1;

    logic rx_valid, rx_ready, dp_valid, dp_ready, dp_sop, dp_eop, proto_err;
    logic ep_ready, tx_valid, tx_ready;
    logic [7:0] rx_byte, dp_data, tx_byte;

    assign dp_ready = bp_en ? lfsr[5] : 1'b1;
    assign tx_ready = loop ? rx_ready : (bp_en ? lfsr[2] : 1'b1);
    assign rx_valid = loop ? tx_valid : rv_drv;
    assign rx_byte  = loop ? tx_byte  : rb_drv;

    pfc_codec dut (.*);

    always @(posedge clk) begin
        #1;
        lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    end

    bq_t txq;
    dq_t dpq;
    int  checks = 0, fails = 0;
    bit  done = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (tx_valid && tx_ready && !loop) txq.push_back(tx_byte);
            if (dp_valid && dp_ready) dpq.push_back({dp_sop, dp_eop, dp_data});
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic chk_tx(input string tag, input bq_t exp);
        bit ok = (txq.size() == exp.size());
        int at = -1;
        for (int i = 0; ok && i < exp.size(); i++)
            if (txq[i] !== exp[i]) begin ok = 1'b0; at = i; end
        checks++;
        if (!ok) begin
            fails++;
            if (at < 0) $display("FAIL %s: got %0d bytes expected %0d bytes", tag, txq.size(), exp.size());
            else $display("FAIL %s: byte %0d got %h expected %h", tag, at, txq[at], exp[at]);
        end
        txq.delete();
    endtask

    task automatic chk_dp(input string tag, input dq_t exp);
        bit ok = (dpq.size() == exp.size());
        int at = -1;
        for (int i = 0; ok && i < exp.size(); i++)
            if (dpq[i] !== exp[i]) begin ok = 1'b0; at = i; end
        checks++;
        if (!ok) begin
            fails++;
            if (at < 0) $display("FAIL %s: got %0d entries expected %0d entries", tag, dpq.size(), exp.size());
            else $display("FAIL %s: entry %0d got %h expected %h", tag, at, dpq[at], exp[at]);
        end
        dpq.delete();
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; ep_valid = 1'b0; rv_drv = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        txq.delete(); dpq.delete();
    endtask

    task automatic drain();
        int idle = 0;
        while (idle < 4) begin
            @(negedge clk);
            if (!tx_valid && !dp_valid) idle++; else idle = 0;
        end
        @(posedge clk); #1;
    endtask

    task automatic enc_send(input bq_t d);
        bit hs;
        for (int i = 0; i < d.size(); i++) begin
            ep_valid = 1'b1; ep_data = d[i];
            ep_sop = (i == 0); ep_eop = (i == d.size() - 1);
            do begin
                @(negedge clk); hs = ep_ready;
                @(posedge clk); #1;
            end while (!hs);
        end
        ep_valid = 1'b0;
        drain();
    endtask

    task automatic raw_send(input bq_t d);
        bit hs;
        for (int i = 0; i < d.size(); i++) begin
            rv_drv = 1'b1; rb_drv = d[i];
            do begin
                @(negedge clk); hs = rx_ready;
                @(posedge clk); #1;
            end while (!hs);
        end
        rv_drv = 1'b0;
        drain();
    endtask

    task automatic add_enc(ref bq_t q, input logic [7:0] b);
        if (b == 8'h7A || b == 8'h7B || b == 8'h7C || b == 8'h7D) begin
            q.push_back(8'h7D); q.push_back(b ^ 8'h20);
        end else begin
            q.push_back(b);
        end
    endtask

    task automatic model_pkt(ref bq_t q, input bq_t d);
        q = '{8'h7A, 8'h7C, 8'h00};
        for (int i = 0; i < d.size(); i++) begin
            if (i == d.size() - 1) q.push_back(8'h7B);
            add_enc(q, d[i]);
        end
    endtask

    task automatic bad_case(input string tag, input logic [7:0] a, input logic [7:0] b);
        do_reset();
        raw_send('{8'h7A, 8'h7C, 8'h00, a, b, 8'h44, 8'h7B, 8'h45});
        chk_dp({tag, " nothing emitted"}, '{});
        chk({tag, " error flag"}, 32'(proto_err), 32'd1);
    endtask

    initial begin
        bq_t d, exp;
        dq_t dexp;
        do_reset();
        // R9 reset state
        chk("R9 err after reset", 32'(proto_err), 32'd0);
        chk("R9 dp_valid after reset", 32'(dp_valid), 32'd0);
        chk("R9 tx_valid after reset", 32'(tx_valid), 32'd0);
        chk("R9 ep_ready after reset", 32'(ep_ready), 32'd1);

        // R1 R2 R3 R10: encoder sweep under back-pressure
        bp_en = 1'b1;
        for (int v = 0; v < 256; v++) begin
            d = '{8'(v), 8'(v + 3)};
            model_pkt(exp, d);
            enc_send(d);
            chk_tx($sformatf("R1 R2 R3 encode pair v=%0d", v), exp);
        end
        d = '{8'h7D};
        model_pkt(exp, d);
        enc_send(d);
        chk_tx("R3 single escaped byte", exp);
        d = '{8'h01, 8'h02, 8'h03, 8'h04};
        model_pkt(exp, d);
        enc_send(d);
        chk_tx("R2 R3 plain four bytes", exp);

        // R11 R5 R10: loopback sweep
        loop = 1'b1;
        for (int v = 0; v < 256; v++) begin
            enc_send('{8'(v)});
            chk_dp($sformatf("R11 R10 loopback byte v=%0d", v), '{{2'b11, 8'(v)}});
        end
        enc_send('{8'h7A, 8'h7B, 8'h7C, 8'h7D, 8'h00, 8'hFF});
        chk_dp("R11 loopback special packet",
               '{10'h27A, 10'h07B, 10'h07C, 10'h07D, 10'h000, 10'h1FF});
        chk("R11 no error in loopback", 32'(proto_err), 32'd0);
        loop = 1'b0;

        // R4 R5 R8: direct decoding
        do_reset();
        raw_send('{8'h11, 8'h7B, 8'h55, 8'h7D, 8'h00});
        chk_dp("R4 bytes before start dropped", '{});
        raw_send('{8'h7A, 8'h7C, 8'h00, 8'h41, 8'h7D, 8'h5A, 8'h7B, 8'h42});
        chk_dp("R5 flags and unescape", '{10'h241, 10'h07A, 10'h142});
        raw_send('{8'h7A, 8'h7C, 8'h00, 8'h7B, 8'h7D, 8'h5B});
        chk_dp("R5 escaped last byte", '{10'h37B});
        raw_send('{8'h66, 8'h7B, 8'h67});
        chk_dp("R4 bytes after packet end dropped", '{});
        raw_send('{8'h7A, 8'h7C, 8'h00, 8'h10, 8'h20, 8'h7A, 8'h7C, 8'h00, 8'h30, 8'h7B, 8'h40});
        chk_dp("R8 restart on second start", '{10'h210, 10'h020, 10'h230, 10'h140});
        chk("R5 no error on legal stream", 32'(proto_err), 32'd0);

        // R6 R9: bad channel, then resume
        raw_send('{8'h7A, 8'h7C, 8'h01, 8'h50, 8'h7B, 8'h51});
        chk_dp("R6 nonzero channel drops packet", '{});
        chk("R6 error on nonzero channel", 32'(proto_err), 32'd1);
        raw_send('{8'h7A, 8'h7C, 8'h00, 8'h7B, 8'h99});
        chk_dp("R6 resumes at next start", '{10'h399});
        chk("R9 error stays set", 32'(proto_err), 32'd1);

        // R7: misplaced reserved codes
        bad_case("R7 esc esc", 8'h7D, 8'h7D);
        bad_case("R7 esc end", 8'h7D, 8'h7B);
        bad_case("R7 esc chan", 8'h7D, 8'h7C);
        bad_case("R7 end end", 8'h7B, 8'h7B);
        bad_case("R7 end chan", 8'h7B, 8'h7C);
        do_reset();
        raw_send('{8'h7A, 8'h7C, 8'h00, 8'h21, 8'h7D, 8'h7D, 8'h44, 8'h7B, 8'h45});
        chk_dp("R7 error mid packet drops rest", '{10'h221});
        chk("R7 error flag mid packet", 32'(proto_err), 32'd1);

        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R10 watchdog: got timeout expected completion");
            finish_run();
        end
    end
endmodule